// File: doc/BRIEF.md
# Single-Precision Add/Subtract Unit with Selectable Rounding

This unit adds or subtracts two IEEE-754 binary32 values and presents the result one clock later. A select input chooses between addition and subtraction. A two-bit mode input chooses among four rounding directions. Normal and subnormal numbers, signed zeros, infinities and NaNs are all handled. Four exception flags come back with every result.

A second mode input sets the NaN policy. The standard policy quiets any NaN it returns and prefers the NaN in the second operand. The legacy policy returns the first NaN operand bit for bit and raises no flag for it.

An operation is launched by raising `in_valid` for one cycle with the operands and modes. The registered result and its flags appear with `out_valid` one cycle later.

Top module: `fp32_addsub_rnd`

## Requirements
- R1: `rnd_mode` selects the rounding: 00 round to nearest, ties to even; 01 toward zero; 10 toward +infinity; 11 toward -infinity. 0x3fc00000 + 0x34400000 gives 0x3fc00002, 0x3fc00001, 0x3fc00002 and 0x3fc00001 in those four modes, and each raises inexact.
- R2: 0x7f7fffff + 0x7f7fffff gives 0x7f800000 under modes 00 and 10, and gives 0x7f7fffff under modes 01 and 11. Overflow and inexact are both set.
- R3: When the operation effectively subtracts one infinity from another of the same sign (+inf + -inf, or +inf - +inf), the result is 0x7fc00000 and the flags are exactly {invalid}.
- R4: When one operand is infinite, the other is finite and neither is NaN, the result is that infinity with no flags. When the second operand is the infinite one and `do_sub` is set, its sign is inverted.
- R5: With `nan_legacy`=0, a NaN result is the chosen NaN with fraction bit 22 forced to 1. Invalid is raised only if some operand is a signalling NaN (fraction bit 22 clear). 1.5 + 0x7f800001 gives 0x7fc00001 with invalid; 1.5 + 0x7fc00001 gives 0x7fc00001 with no flags.
- R6: With `nan_legacy`=0 and both operands NaN, the second operand is the one quieted and returned. 0x7f800001 + 0x7fbfffff gives 0x7fffffff, and 0x7fbfffff + 0x7f800001 gives 0x7fc00001, both with invalid.
- R7: With `nan_legacy`=1, a NaN result is the first operand when that operand is NaN, and otherwise the second. It is copied unchanged, and all flags are zero.
- R8: Gradual underflow: 0x00800001 - 0x00800000 gives exactly 0x00000001 with no flags.
- R9: `do_sub`=1 negates the second operand. 0x3f800001 - 0x33800000 gives 0x3f800000 under modes 00, 01 and 11, and 0x3f800001 under mode 10, with inexact. 0x3f800000 - 0x40000000 gives 0xbf800000 exactly.
- R10: An exact zero from operands of opposite effective sign is +0 (0x00000000) in modes 00, 01 and 10, and -0 (0x80000000) in mode 11.
- R11: `exc_flags` packs {invalid, overflow, underflow, inexact} in bits 3 down to 0. An exact finite result has all flags zero, for example 1.0 + 1.0 = 0x40000000.
- R12: The result and flags are registered. `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1. While `rst_n` is low, `out_valid`, `result` and `exc_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Launches an operation on the current inputs |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| do_sub | input | 1 | 1 = subtract op_b, 0 = add |
| rnd_mode | input | 2 | Rounding direction (see R1) |
| nan_legacy | input | 1 | 1 = legacy NaN pass-through, 0 = quieting policy |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Rounded sum or difference |
| exc_flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
The assertions assume that every input is at a known value in any cycle where `in_valid` is high, and that the whole operation is sampled at the one rising edge of that cycle. The NaN and infinity properties also assume that the operand classes seen at that edge are the ones the registered result reflects. The bench keeps to this. It changes inputs only on falling edges and holds them through the launching edge. It raises `in_valid` for one cycle per operation and reads the outputs on the next falling edge, once the single register has captured them.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  localparam int FL_NV = 3;
  localparam int FL_OF = 2;
  localparam int FL_UF = 1;
  localparam int FL_NX = 0;

  // Whether to add one ulp to the truncated magnitude
  function automatic logic round_inc(input logic [1:0] rm, input logic sgn,
                                     input logic lsb, input logic rnd, input logic stk);
    logic inc;
    case (rmode_e'(rm))
      RM_NEAR: inc = rnd & (stk | lsb);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = (rnd | stk) & ~sgn;
      default: inc = (rnd | stk) & sgn;
    endcase
    return inc;
  endfunction

  // Whether an overflowing result saturates to infinity
  function automatic logic ovf_to_inf(input logic [1:0] rm, input logic sgn);
    logic r;
    case (rmode_e'(rm))
      RM_NEAR: r = 1'b1;
      RM_ZERO: r = 1'b0;
      RM_UP:   r = ~sgn;
      default: r = sgn;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] x,
  output logic           sgn,
  output logic [EW-1:0]  exp_eff,
  output logic [MW:0]    sig,
  output logic           is_nan,
  output logic           is_snan,
  output logic           is_inf
);
  logic [EW-1:0] ef;
  logic [MW-1:0] fr;
  logic          e_max, e_min;

  always_comb begin
    sgn     = x[EW+MW];
    ef      = x[EW+MW-1:MW];
    fr      = x[MW-1:0];
    e_max   = &ef;
    e_min   = ~|ef;
    exp_eff = e_min ? EW'(1) : ef;
    sig     = {~e_min, fr};
    is_nan  = e_max & (|fr);
    is_snan = is_nan & ~fr[MW-1];
    is_inf  = e_max & ~(|fr);
  end
endmodule

// File: rtl/fpadd_special.sv
module fpadd_special #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] a,
  input  logic [EW+MW:0] b,
  input  logic           b_sgn_eff,
  input  logic           eff_sub,
  input  logic           nan_a,
  input  logic           nan_b,
  input  logic           snan_a,
  input  logic           snan_b,
  input  logic           inf_a,
  input  logic           inf_b,
  input  logic           legacy,
  output logic           hit,
  output logic [EW+MW:0] val,
  output logic           nv,
  output logic           nan_any,
  output logic           inf_clash
);
  localparam logic [EW+MW:0] QBIT = (EW+MW+1)'(1) << (MW-1);
  localparam logic [EW+MW:0] DNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  always_comb begin
    nan_any   = nan_a | nan_b;
    inf_clash = inf_a & inf_b & eff_sub;
    hit       = nan_any | inf_a | inf_b;
    nv        = 1'b0;
    val       = '0;
    if (nan_any) begin
      if (legacy) begin
        val = nan_a ? a : b;
      end else begin
        val = (nan_b ? b : a) | QBIT;
        nv  = snan_a | snan_b;
      end
    end else if (inf_clash) begin
      val = DNAN;
      nv  = 1'b1;
    end else if (inf_a) begin
      val = a;
    end else if (inf_b) begin
      val = {b_sgn_eff, b[EW+MW-1:0]};
    end
  end
endmodule

// File: rtl/fpadd_datapath.sv
module fpadd_datapath
  import fpadd_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic           sa,
  input  logic [EW-1:0]  ea,
  input  logic [MW:0]    siga,
  input  logic           sb,
  input  logic [EW-1:0]  eb,
  input  logic [MW:0]    sigb,
  input  logic           eff_sub,
  input  logic [1:0]     rm,
  output logic [EW+MW:0] res,
  output logic [3:0]     flags
);
  localparam int W   = MW + 1;
  localparam int S   = W + 3;
  localparam int LZW = $clog2(S + 1);
  localparam int EXW = EW + 1;
  localparam logic [EXW-1:0] EMAX = {1'b0, {EW{1'b1}}};

  logic              a_ge, sgn, zsign;
  logic [EW-1:0]     e_big, e_small, d;
  logic [MW:0]       sig_big, sig_small;
  logic [S-1:0]      sm, shifted, lostbits, n;
  logic [S:0]        small_al, big_ext, sum;
  logic [LZW-1:0]    lz;
  logic [EXW-1:0]    lim, lz_x, shl, e_n, exp_f;
  logic [MW-1:0]     frac;
  logic              hidden, lsb, rnd, stk, inexact, inc, ovf;
  logic [EXW+MW-1:0] packed_r;

  // Align: larger magnitude first, smaller shifted right with sticky
  always_comb begin
    a_ge      = {ea, siga} >= {eb, sigb};
    e_big     = a_ge ? ea : eb;
    e_small   = a_ge ? eb : ea;
    sig_big   = a_ge ? siga : sigb;
    sig_small = a_ge ? sigb : siga;
    sgn       = a_ge ? sa : sb;
    d         = e_big - e_small;
    sm        = {sig_small, 3'b000};
    shifted   = (d >= EW'(S)) ? '0 : (sm >> d);
    lostbits  = (d >= EW'(S)) ? sm : (sm << (S - int'(d)));
    small_al  = {1'b0, shifted[S-1:1], shifted[0] | (|lostbits)};
    big_ext   = {1'b0, sig_big, 3'b000};
    sum       = eff_sub ? (big_ext - small_al) : (big_ext + small_al);
  end

  // Leading-zero count of the sum below its carry bit
  always_comb begin
    lz = LZW'(S);
    for (int i = 0; i < S; i++) begin
      if (sum[i]) lz = LZW'(S - 1 - i);
    end
  end

  // Normalize, stopping at the minimum exponent for subnormals
  always_comb begin
    lim  = {1'b0, e_big} - EXW'(1);
    lz_x = EXW'(lz);
    shl  = (lz_x < lim) ? lz_x : lim;
    if (sum[S]) begin
      n   = {sum[S:2], sum[1] | sum[0]};
      e_n = {1'b0, e_big} + EXW'(1);
    end else begin
      n   = sum[S-1:0] << shl;
      e_n = {1'b0, e_big} - shl;
    end
    hidden = n[S-1];
    exp_f  = hidden ? e_n : '0;
    frac   = n[S-2:3];
    lsb    = n[3];
    rnd    = n[2];
    stk    = |n[1:0];
  end

  // Round: carries ripple from fraction into exponent field
  always_comb begin
    inexact  = rnd | stk;
    inc      = round_inc(rm, sgn, lsb, rnd, stk);
    packed_r = {exp_f, frac} + (EXW+MW)'(inc);
    ovf      = packed_r[EXW+MW-1:MW] >= EMAX;
    zsign    = eff_sub ? (rm == RM_DOWN) : sgn;
    flags    = '0;
    if (sum == '0) begin
      res = {zsign, {(EW+MW){1'b0}}};
    end else if (ovf) begin
      res = ovf_to_inf(rm, sgn) ? {sgn, {EW{1'b1}}, {MW{1'b0}}}
                                : {sgn, {(EW-1){1'b1}}, 1'b0, {MW{1'b1}}};
      flags[FL_OF] = 1'b1;
      flags[FL_NX] = 1'b1;
    end else begin
      res = {sgn, packed_r[EW+MW-1:0]};
      flags[FL_NX] = inexact;
      flags[FL_UF] = inexact & ~hidden;
    end
  end
endmodule

// File: rtl/fp32_addsub_rnd.sv
module fp32_addsub_rnd
  import fpadd_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [EW+MW:0]   op_a,
  input  logic [EW+MW:0]   op_b,
  input  logic             do_sub,
  input  logic [1:0]       rnd_mode,
  input  logic             nan_legacy,
  output logic             out_valid,
  output logic [EW+MW:0]   result,
  output logic [3:0]       exc_flags
);
  localparam int XW = EW + MW + 1;
  localparam logic [XW-1:0] DNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  logic          a_sgn, b_sgn, b_sgn_eff, eff_sub;
  logic [EW-1:0] a_exp, b_exp;
  logic [MW:0]   a_sig, b_sig;
  logic          a_nan, a_snan, a_inf, b_nan, b_snan, b_inf;
  logic          sp_hit, sp_nv, sp_nan_any, sp_inf_clash;
  logic [XW-1:0] sp_res, dp_res, nxt_res;
  logic [3:0]    dp_flags, nxt_flags;

  fpadd_unpack #(.EW(EW), .MW(MW)) u_unpack_a (
    .x(op_a), .sgn(a_sgn), .exp_eff(a_exp), .sig(a_sig),
    .is_nan(a_nan), .is_snan(a_snan), .is_inf(a_inf)
  );

  fpadd_unpack #(.EW(EW), .MW(MW)) u_unpack_b (
    .x(op_b), .sgn(b_sgn), .exp_eff(b_exp), .sig(b_sig),
    .is_nan(b_nan), .is_snan(b_snan), .is_inf(b_inf)
  );

  assign b_sgn_eff = b_sgn ^ do_sub;
  assign eff_sub   = a_sgn ^ b_sgn_eff;

  fpadd_special #(.EW(EW), .MW(MW)) u_special (
    .a(op_a), .b(op_b), .b_sgn_eff(b_sgn_eff), .eff_sub(eff_sub),
    .nan_a(a_nan), .nan_b(b_nan), .snan_a(a_snan), .snan_b(b_snan),
    .inf_a(a_inf), .inf_b(b_inf), .legacy(nan_legacy),
    .hit(sp_hit), .val(sp_res), .nv(sp_nv),
    .nan_any(sp_nan_any), .inf_clash(sp_inf_clash)
  );

  fpadd_datapath #(.EW(EW), .MW(MW)) u_datapath (
    .sa(a_sgn), .ea(a_exp), .siga(a_sig),
    .sb(b_sgn_eff), .eb(b_exp), .sigb(b_sig),
    .eff_sub(eff_sub), .rm(rnd_mode),
    .res(dp_res), .flags(dp_flags)
  );

  always_comb begin
    nxt_res   = sp_hit ? sp_res : dp_res;
    nxt_flags = sp_hit ? {sp_nv, 3'b000} : dp_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      exc_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        exc_flags <= nxt_flags;
      end
    end
  end

  // R12: one-cycle latency of the valid strobe
  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: opposing infinities give the default NaN with invalid only
  p_inf_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sp_inf_clash) |=> (result == DNAN && exc_flags == 4'b1000));

  // R4: exact infinity from a finite partner raises nothing
  p_inf_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sp_hit && !sp_nan_any && !sp_inf_clash) |=> (exc_flags == 4'b0000));

  // R5: quieting policy always returns a quiet NaN
  p_quiet_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nan_legacy && sp_nan_any) |=> (result[MW-1] && (&result[XW-2:MW])));

  // R7: legacy policy is silent on NaNs
  p_legacy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_legacy && sp_nan_any) |=> (exc_flags == 4'b0000));

  // R2: overflow always comes with inexact
  p_ovf_inexact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_flags[FL_OF]) |-> exc_flags[FL_NX]);
endmodule

// File: tb/sim_fp32_addsub_rnd.sv
module sim_fp32_addsub_rnd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        do_sub = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        nan_legacy = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  exc_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  fp32_addsub_rnd u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .do_sub(do_sub), .rnd_mode(rnd_mode), .nan_legacy(nan_legacy),
    .out_valid(out_valid), .result(result), .exc_flags(exc_flags)
  );

  // Flag codes {invalid, overflow, underflow, inexact}
  localparam logic [3:0] F0  = 4'b0000;
  localparam logic [3:0] FNX = 4'b0001;
  localparam logic [3:0] FOX = 4'b0101;
  localparam logic [3:0] FNV = 4'b1000;

  task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic sub, input logic [1:0] rm, input logic leg,
                     input logic [31:0] exp_r, input logic [3:0] exp_f);
    @(negedge clk);
    op_a = a; op_b = b; do_sub = sub; rnd_mode = rm; nan_legacy = leg;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_checks++;
    if (!out_valid || result !== exp_r || exc_flags !== exp_f) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h sub=%0d rm=%0d leg=%0d got valid=%0d res=%h flags=%b expected valid=1 res=%h flags=%b",
               req, a, b, sub, rm, leg, out_valid, result, exc_flags, exp_r, exp_f);
    end
  endtask

  task automatic t_reset_r12;
    n_checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || exc_flags !== 4'h0) begin
      n_fail++;
      $display("FAIL R12 reset: got valid=%0d res=%h flags=%b expected 0 0 0",
               out_valid, result, exc_flags);
    end
  endtask

  task automatic t_idle_r12;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 idle: got valid=%0d expected 0", out_valid);
    end
  endtask

  task automatic t_round_r1;
    run("R1", 32'h3fc00000, 32'h34400000, 1'b0, 2'b00, 1'b0, 32'h3fc00002, FNX);
    run("R1", 32'h3fc00000, 32'h34400000, 1'b0, 2'b01, 1'b0, 32'h3fc00001, FNX);
    run("R1", 32'h3fc00000, 32'h34400000, 1'b0, 2'b10, 1'b0, 32'h3fc00002, FNX);
    run("R1", 32'h3fc00000, 32'h34400000, 1'b0, 2'b11, 1'b0, 32'h3fc00001, FNX);
  endtask

  task automatic t_overflow_r2;
    run("R2", 32'h7f7fffff, 32'h7f7fffff, 1'b0, 2'b00, 1'b0, 32'h7f800000, FOX);
    run("R2", 32'h7f7fffff, 32'h7f7fffff, 1'b0, 2'b01, 1'b0, 32'h7f7fffff, FOX);
    run("R2", 32'h7f7fffff, 32'h7f7fffff, 1'b0, 2'b10, 1'b0, 32'h7f800000, FOX);
    run("R2", 32'h7f7fffff, 32'h7f7fffff, 1'b0, 2'b11, 1'b0, 32'h7f7fffff, FOX);
  endtask

  task automatic t_inf_clash_r3;
    run("R3", 32'h7f800000, 32'hff800000, 1'b0, 2'b00, 1'b0, 32'h7fc00000, FNV);
    run("R3", 32'h7f800000, 32'h7f800000, 1'b1, 2'b01, 1'b1, 32'h7fc00000, FNV);
  endtask

  task automatic t_inf_pass_r4;
    run("R4", 32'h3fc00000, 32'h7f800000, 1'b0, 2'b00, 1'b0, 32'h7f800000, F0);
    run("R4", 32'h3fc00000, 32'h7f800000, 1'b1, 2'b00, 1'b0, 32'hff800000, F0);
    run("R4", 32'hff800000, 32'h3fc00000, 1'b0, 2'b10, 1'b0, 32'hff800000, F0);
  endtask

  task automatic t_ieee_nan_r5;
    run("R5", 32'h3fc00000, 32'h7f800001, 1'b0, 2'b00, 1'b0, 32'h7fc00001, FNV);
    run("R5", 32'h3fc00000, 32'h7fc00001, 1'b0, 2'b00, 1'b0, 32'h7fc00001, F0);
  endtask

  task automatic t_ieee_two_nan_r6;
    run("R6", 32'h7f800001, 32'h7fbfffff, 1'b0, 2'b00, 1'b0, 32'h7fffffff, FNV);
    run("R6", 32'h7fbfffff, 32'h7f800001, 1'b0, 2'b00, 1'b0, 32'h7fc00001, FNV);
    run("R6", 32'h7fc00001, 32'h7fbfffff, 1'b0, 2'b00, 1'b0, 32'h7fffffff, FNV);
    run("R6", 32'h7fbfffff, 32'h7fc00001, 1'b0, 2'b00, 1'b0, 32'h7fc00001, FNV);
  endtask

  task automatic t_legacy_r7;
    run("R7", 32'h3fc00000, 32'h7f800001, 1'b0, 2'b00, 1'b1, 32'h7f800001, F0);
    run("R7", 32'h7f800001, 32'h7fbfffff, 1'b0, 2'b00, 1'b1, 32'h7f800001, F0);
    run("R7", 32'h7fbfffff, 32'h7f800001, 1'b0, 2'b00, 1'b1, 32'h7fbfffff, F0);
    run("R7", 32'h7fc00001, 32'h7fbfffff, 1'b0, 2'b00, 1'b1, 32'h7fc00001, F0);
  endtask

  task automatic t_subnormal_r8;
    run("R8", 32'h00800001, 32'h00800000, 1'b1, 2'b00, 1'b0, 32'h00000001, F0);
  endtask

  task automatic t_sub_round_r9;
    run("R9", 32'h3f800001, 32'h33800000, 1'b1, 2'b00, 1'b0, 32'h3f800000, FNX);
    run("R9", 32'h3f800001, 32'h33800000, 1'b1, 2'b01, 1'b0, 32'h3f800000, FNX);
    run("R9", 32'h3f800001, 32'h33800000, 1'b1, 2'b10, 1'b0, 32'h3f800001, FNX);
    run("R9", 32'h3f800001, 32'h33800000, 1'b1, 2'b11, 1'b0, 32'h3f800000, FNX);
    run("R9", 32'h3f800000, 32'h40000000, 1'b1, 2'b00, 1'b0, 32'hbf800000, F0);
  endtask

  task automatic t_zero_sign_r10;
    run("R10", 32'h3fc00000, 32'h3fc00000, 1'b1, 2'b00, 1'b0, 32'h00000000, F0);
    run("R10", 32'h3fc00000, 32'hbfc00000, 1'b0, 2'b10, 1'b0, 32'h00000000, F0);
    run("R10", 32'h3fc00000, 32'h3fc00000, 1'b1, 2'b11, 1'b0, 32'h80000000, F0);
    run("R10", 32'hbfc00000, 32'h3fc00000, 1'b0, 2'b11, 1'b0, 32'h80000000, F0);
  endtask

  task automatic t_exact_r11;
    run("R11", 32'h3f800000, 32'h3f800000, 1'b0, 2'b00, 1'b0, 32'h40000000, F0);
    run("R11", 32'h40400000, 32'h3f800000, 1'b1, 2'b11, 1'b0, 32'h40000000, F0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_r12();
    rst_n = 1'b1;
    t_idle_r12();
    t_round_r1();
    t_overflow_r2();
    t_inf_clash_r3();
    t_inf_pass_r4();
    t_ieee_nan_r5();
    t_ieee_two_nan_r6();
    t_legacy_r7();
    t_subnormal_r8();
    t_sub_round_r9();
    t_zero_sign_r10();
    t_exact_r11();
    t_idle_r12();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got run still active expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule